// File: doc/BRIEF.md
# External Interrupt Sense Controller

The block watches two external interrupt pins and turns their activity into interrupt requests for a processor core. Each pin has a 2-bit sense code that picks one of four trigger conditions. Code 00 selects a low level, code 01 selects any change, code 10 selects a falling edge and code 11 selects a rising edge. Every pin is first brought into the clock domain through a synchronizer. Edges are found only by comparing successive synchronized samples.

Level requests follow the synchronized pin and are never stored. An edge or a change in the other modes sets a per-pin pending flag. That flag holds until an acknowledge pulse clears it, until software writes 1 to it, or until the pin's sense code is changed. A request leaves the block only while the global interrupt enable input and the pin's mask bit are both 1. A byte-wide register port gives the core access to the sense codes, the mask bits and the pending flags.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all three registers read 0 and both `irqOut` bits are 0. This means low-level sensing with both pins masked.
- R2: With sense code 00, `irqOut[i]` is high exactly while the synchronized pin is low, and no state is kept. A pin change made before clock edge k appears at `irqOut` after edge k+1.
- R3: With sense code 01, any change of the synchronized pin sets that pin's pending flag.
- R4: With sense code 10, only a 1-to-0 change of the synchronized pin sets the pending flag.
- R5: With sense code 11, only a 0-to-1 change of the synchronized pin sets the pending flag.
- R6: Edges are detected on synchronized samples. A pin change made before clock edge k shows in the pending flag after edge k+2 and not earlier, and any level held for at least two clocks is seen.
- R7: `irqOut[i]` can be 1 only while `gie` is 1 and mask bit i is 1. In the edge modes it equals the pending flag under that gating.
- R8: The register map is as follows. Address 0x35 is the control register: bits 3:2 hold the pin 1 sense code and bits 1:0 the pin 0 sense code. Address 0x3B is the mask register: bit 7 enables pin 1 and bit 6 enables pin 0. Address 0x3A is the pending register: bit 7 is the pin 1 flag and bit 6 the pin 0 flag. Every other address reads 0.
- R9: A pending flag clears after a cycle with `ackIn[i]` high, or after a write to 0x3A with its bit set to 1. Writing 0 to the bit leaves it unchanged. A new edge in the same cycle wins over the clear.
- R10: A write to 0x35 that changes pin i's sense code clears pin i's pending flag and blocks it from being set in that cycle. Rewriting the same code has no effect on the flag.
- R11: Unimplemented register bits read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 2 | Asynchronous external interrupt pins |
| gie | input | 1 | Global interrupt enable from the core |
| ackIn | input | 2 | Per-pin acknowledge pulse |
| regAddr | input | 6 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| irqOut | output | 2 | Gated interrupt requests to the core |

## Verification
The hardest cases to reach are cycles where two things hit one pending flag at once. One case is a sense-code change landing in the same cycle as a synchronized edge. Another is an acknowledge or write-1 clear coinciding with a fresh edge. Directed sequences place a pin change exactly two clocks ahead of the conflicting write or acknowledge. A long random phase then mixes pin toggles, short pulses, acknowledges and register writes, so these collisions recur many times. Every cycle is compared against a behavioural model that keeps a history queue of pin samples.

// File: rtl/eis_pkg.sv
package eis_pkg;
  localparam int NPINS = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  typedef logic [1:0] sense_t;
  localparam sense_t SENSE_LOW  = 2'b00;
  localparam sense_t SENSE_ANY  = 2'b01;
  localparam sense_t SENSE_FALL = 2'b10;
  localparam sense_t SENSE_RISE = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic [NPINS-1:0] modeChg;  // sense code changed: clear and block set
    logic [NPINS-1:0] clrReq;   // acknowledge or write-1 clear
  } strobe_t;
endpackage

// File: rtl/eis_ctrl.sv
module eis_ctrl
  import eis_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h35,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h3B,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [NPINS-1:0]     ackIn,
  input  logic [NPINS-1:0]     pendIn,
  output logic [2*NPINS-1:0]   senseCode,
  output logic [NPINS-1:0]     maskBits,
  output strobe_t              strobe,
  output logic [DATA_W-1:0]    regRdData
);
  localparam int CODE_W  = 2 * NPINS;
  localparam int FLAG_LSB = DATA_W - NPINS;

  logic wrCtrl, wrMask, wrFlag;
  assign wrCtrl = regWrEn && (regAddr == CTRL_ADDR);
  assign wrMask = regWrEn && (regAddr == MASK_ADDR);
  assign wrFlag = regWrEn && (regAddr == FLAG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseCode <= '0;
      maskBits  <= '0;
    end else begin
      if (wrCtrl) senseCode <= regWrData[CODE_W-1:0];
      if (wrMask) maskBits  <= regWrData[DATA_W-1:FLAG_LSB];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_strobe
    assign strobe.modeChg[i] = wrCtrl && (regWrData[2*i +: 2] != senseCode[2*i +: 2]);
    assign strobe.clrReq[i]  = ackIn[i] || (wrFlag && regWrData[FLAG_LSB+i]);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_ADDR)      regRdData[CODE_W-1:0] = senseCode;
    else if (regAddr == MASK_ADDR) regRdData[DATA_W-1:FLAG_LSB] = maskBits;
    else if (regAddr == FLAG_ADDR) regRdData[DATA_W-1:FLAG_LSB] = pendIn;
  end
endmodule

// File: rtl/eis_datapath.sv
module eis_datapath
  import eis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPINS-1:0]   pinIn,
  input  logic               gie,
  input  logic [2*NPINS-1:0] senseCode,
  input  logic [NPINS-1:0]   maskBits,
  input  strobe_t            strobe,
  output logic [NPINS-1:0]   pendOut,
  output logic [NPINS-1:0]   irqOut
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncChain;
    logic prevVal, sampled, rise, fall, edgeHit, pend;
    sense_t code;

    assign code    = senseCode[2*i +: 2];
    assign sampled = syncChain[TOP];
    assign rise    = sampled && !prevVal;
    assign fall    = !sampled && prevVal;

    always_comb begin
      case (code)
        SENSE_ANY:  edgeHit = rise || fall;
        SENSE_FALL: edgeHit = fall;
        SENSE_RISE: edgeHit = rise;
        default:    edgeHit = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '1;
        prevVal   <= 1'b1;
        pend      <= 1'b0;
      end else begin
        syncChain <= {syncChain[TOP-1:0], pinIn[i]};
        prevVal   <= sampled;
        if (strobe.modeChg[i])     pend <= 1'b0;
        else if (edgeHit)          pend <= 1'b1;
        else if (strobe.clrReq[i]) pend <= 1'b0;
      end
    end

    assign pendOut[i] = pend;
    assign irqOut[i]  = gie && maskBits[i] && ((code == SENSE_LOW) ? !sampled : pend);
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  pinIn,
  input  logic        gie,
  input  logic [1:0]  ackIn,
  input  logic [5:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  output logic [1:0]  irqOut
);
  logic [2*NPINS-1:0] senseCode;
  logic [NPINS-1:0]   maskBits;
  logic [NPINS-1:0]   pendBits;
  strobe_t            strobe;

  eis_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .ackIn(ackIn), .pendIn(pendBits),
    .senseCode(senseCode), .maskBits(maskBits), .strobe(strobe),
    .regRdData(regRdData)
  );

  eis_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .gie(gie),
    .senseCode(senseCode), .maskBits(maskBits), .strobe(strobe),
    .pendOut(pendBits), .irqOut(irqOut)
  );
endmodule

// File: rtl/eis_checker.sv
module eis_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pinIn,
  input logic       gie,
  input logic [5:0] regAddr,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic [1:0] irqOut,
  input logic [3:0] senseCode,
  input logic [1:0] maskBits,
  input logic [1:0] pendBits
);
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqOut == 2'b00));

  p_level_pin0_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd3 && senseCode[1:0] == 2'b00 && gie && maskBits[0])
      |-> (irqOut[0] == !$past(pinIn[0], 2)));

  p_level_pin1_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd3 && senseCode[3:2] == 2'b00 && gie && maskBits[1])
      |-> (irqOut[1] == !$past(pinIn[1], 2)));

  p_gie_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> (irqOut == 2'b00));

  p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~maskBits) == 2'b00));

  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 6'h35 && regWrData[1:0] != senseCode[1:0]) |=> !pendBits[0]);

  p_unimpl_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 6'h35) |-> (regRdData[7:4] == 4'h0));
endmodule

bind ext_irq_sense eis_checker u_chk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .gie(gie), .regAddr(regAddr),
  .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
  .irqOut(irqOut), .senseCode(senseCode), .maskBits(maskBits),
  .pendBits(pendBits)
);

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pinIn = 2'b11;
  logic       gie = 1'b0;
  logic [1:0] ackIn = 2'b00;
  logic [5:0] regAddr = 6'h00;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [1:0] irqOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  ext_irq_sense dut (.*);

  // ---------------- behavioural reference model ----------------
  int mCode[2];
  int mMask[2];
  int mPend[2];
  bit [1:0] hist[$];  // pin samples, newest first

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin mCode[i] = 0; mMask[i] = 0; mPend[i] = 0; end
      hist = {2'b11, 2'b11, 2'b11, 2'b11};
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit cur, old, hit, chg, clr;
        int newCode;
        cur = hist[1][i];
        old = hist[2][i];
        case (mCode[i])
          1: hit = (cur != old);
          2: hit = (old && !cur);
          3: hit = (!old && cur);
          default: hit = 0;
        endcase
        newCode = (regWrData >> (2*i)) & 3;
        chg = regWrEn && regAddr == 6'h35 && newCode != mCode[i];
        clr = ackIn[i] || (regWrEn && regAddr == 6'h3A && regWrData[6+i]);
        if (chg) mPend[i] = 0;
        else if (hit) mPend[i] = 1;
        else if (clr) mPend[i] = 0;
      end
      if (regWrEn && regAddr == 6'h35)
        for (int i = 0; i < 2; i++) mCode[i] = (regWrData >> (2*i)) & 3;
      if (regWrEn && regAddr == 6'h3B)
        for (int i = 0; i < 2; i++) mMask[i] = regWrData[6+i];
      hist.push_front(pinIn);
      void'(hist.pop_back());
    end
  end

  function automatic logic [1:0] expIrq();
    logic [1:0] r;
    for (int i = 0; i < 2; i++) begin
      bit act;
      act = (mCode[i] == 0) ? !hist[1][i] : (mPend[i] != 0);
      r[i] = gie && (mMask[i] != 0) && act;
    end
    return r;
  endfunction

  function automatic logic [7:0] expRd(logic [5:0] a);
    case (a)
      6'h35: return 8'((mCode[1] << 2) | mCode[0]);
      6'h3B: return 8'((mMask[1] << 7) | (mMask[0] << 6));
      6'h3A: return 8'((mPend[1] << 7) | (mPend[0] << 6));
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #4;
    if (rstN && !finished) begin
      compared++;
      if (irqOut !== expIrq()) begin
        mismatched++;
        $display("FAIL R2 R3 R4 R5 R6 R7 R9 R10 irqOut act=%b exp=%b t=%0t", irqOut, expIrq(), $time);
      end
      compared++;
      if (regRdData !== expRd(regAddr)) begin
        mismatched++;
        $display("FAIL R8 R11 regRdData addr=%h act=%h exp=%h t=%0t", regAddr, regRdData, expRd(regAddr), $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic peek(logic [5:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #2; v = regRdData;
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v;
    ticks(3);
    rstN = 1'b1;
    // R1 reset state
    peek(6'h35, v); chk("R1 ctrl reset", v, 8'h00);
    peek(6'h3B, v); chk("R1 mask reset", v, 8'h00);
    peek(6'h3A, v); chk("R1 flag reset", v, 8'h00);
    chk("R1 irq reset", {6'd0, irqOut}, 8'h00);

    // R8 / R11 map and unimplemented bits
    wr(6'h35, 8'hFF); peek(6'h35, v); chk("R11 ctrl upper bits", v, 8'h0F);
    wr(6'h3B, 8'hFF); peek(6'h3B, v); chk("R11 mask lower bits", v, 8'hC0);
    peek(6'h00, v); chk("R8 unmapped address", v, 8'h00);
    wr(6'h35, 8'h00);  // level mode both
    peek(6'h3A, v); chk("R8 flag after mode change", v, 8'h00);

    // R2 level mode
    gie = 1'b1;
    @(negedge clk); pinIn[0] = 1'b0;
    ticks(1); #2; chk("R2 level not yet", {6'd0, irqOut}, 8'h00);
    ticks(1); #2; chk("R2 level asserted", {6'd0, irqOut}, 8'h01);
    @(negedge clk); pinIn[0] = 1'b1;
    ticks(2); #2; chk("R2 level not held", {6'd0, irqOut}, 8'h00);
    peek(6'h3A, v); chk("R2 level sets no flag", v, 8'h00);

    // R5 rising on pin1 with R6 latency
    wr(6'h35, 8'h0C);
    @(negedge clk); pinIn[1] = 1'b0;
    ticks(4);
    @(negedge clk); pinIn[1] = 1'b1;
    peek(6'h3A, v); chk("R6 after one edge", v, 8'h00);
    peek(6'h3A, v); chk("R6 after two edges", v, 8'h00);
    peek(6'h3A, v); chk("R5 rising sets flag", v, 8'h80);
    chk("R7 irq pin1", {6'd0, irqOut}, 8'h02);
    gie = 1'b0; #1; chk("R7 gie low blocks", {6'd0, irqOut}, 8'h00);
    gie = 1'b1;
    wr(6'h3B, 8'h40); #2; chk("R7 mask blocks", {6'd0, irqOut}, 8'h00);
    wr(6'h3B, 8'hC0);
    // R9 acknowledge
    @(negedge clk); ackIn = 2'b10;
    @(negedge clk); ackIn = 2'b00; regAddr = 6'h3A; #2;
    chk("R9 ack clears", regRdData, 8'h00);

    // R4 falling
    wr(6'h35, 8'h08);
    @(negedge clk); pinIn[1] = 1'b0;
    ticks(4);
    peek(6'h3A, v); chk("R4 falling sets flag", v, 8'h80);
    wr(6'h3A, 8'h40); peek(6'h3A, v); chk("R9 write other bit keeps", v, 8'h80);
    wr(6'h3A, 8'h00); peek(6'h3A, v); chk("R9 write zero keeps", v, 8'h80);
    wr(6'h3A, 8'h80); peek(6'h3A, v); chk("R9 write one clears", v, 8'h00);
    @(negedge clk); pinIn[1] = 1'b1;
    ticks(4);
    peek(6'h3A, v); chk("R4 rising ignored", v, 8'h00);

    // R3 any change on pin0, then R10
    wr(6'h35, 8'h09);
    @(negedge clk); pinIn[0] = 1'b0;
    ticks(4);
    peek(6'h3A, v); chk("R3 change sets flag", v, 8'h40);
    wr(6'h35, 8'h09); peek(6'h3A, v); chk("R10 same code keeps", v, 8'h40);
    wr(6'h35, 8'h0B); peek(6'h3A, v); chk("R10 code change clears", v, 8'h00);
    wr(6'h35, 8'h09);
    @(negedge clk); pinIn[0] = 1'b1;
    ticks(4);
    peek(6'h3A, v); chk("R3 second change sets flag", v, 8'h40);
    // R9 edge beats ack in same cycle
    wr(6'h3A, 8'h40);
    @(negedge clk); pinIn[0] = 1'b0;
    ticks(1);
    @(negedge clk); ackIn = 2'b01;
    @(negedge clk); ackIn = 2'b00; regAddr = 6'h3A; #2;
    chk("R9 edge wins over ack", regRdData, 8'h40);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) pinIn[0] = ~pinIn[0];
      if ($urandom_range(4) == 0) pinIn[1] = ~pinIn[1];
      gie = ($urandom_range(7) != 0);
      ackIn = ($urandom_range(9) == 0) ? 2'($urandom_range(3)) : 2'b00;
      regWrEn = ($urandom_range(11) == 0);
      case ($urandom_range(3))
        0: regAddr = 6'h35;
        1: regAddr = 6'h3B;
        2: regAddr = 6'h3A;
        default: regAddr = 6'($urandom_range(63));
      endcase
      regWrData = 8'($urandom_range(255));
    end
    @(negedge clk); regWrEn = 1'b0;
    ticks(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule